// File: doc/BRIEF.md
# Switch Ingress Frame Buffer with Shared-Memory Backpressure

This block is the input buffer of one switch port. A DMA-style writer pushes words into it, each tagged with start-of-frame and end-of-frame markers. The switch core pulls whole frames out of the other side. The writer sees a ready signal. Ready falls at a programmable almost-full level rather than at completely full, so a writer that reacts late can still land a few more words without loss.

The block also watches the total number of free cells in the switch's shared output memory. While that count is below a programmable backpressure threshold, the read side will not begin a new frame. A frame that has already started is always read through to its last word. Held-off frames stay in the buffer, the buffer fills, and ready then drops, so the shared-memory congestion reaches the writer indirectly. A second, memory-full threshold is used only to check the configuration: the backpressure threshold must sit above it, and the almost-full level must leave room for the writer's overrun.

Top module: `ingress_frame_buffer`

## Requirements
- R1: `wr_ready` is a register. In the cycle after each clock edge it is 1 exactly when the occupancy left by that edge is below `af_level`. It therefore drops in the cycle in which occupancy reaches `af_level` and returns in the cycle in which occupancy falls below it, with no hysteresis.
- R2: A write is stored whenever `wr_valid` is 1 and the buffer is not completely full, whatever the state of `wr_ready`. With `af_level` at most DEPTH-4, a writer that stops within 4 words after seeing `wr_ready` low loses no data.
- R3: When no frame is in progress and `free_cells` < `bp_thresh`, `rd_valid` is 0 and no new frame is started.
- R4: Once the first word of a frame has been taken (`rd_valid` and `rd_accept` both 1), `rd_valid` stays 1 until its end-of-frame word is taken, regardless of `free_cells`.
- R5: When no frame is in progress, `rd_valid` is 1 only if the buffer holds at least one complete frame, meaning its end-of-frame word has been written, and `free_cells` >= `bp_thresh`.
- R6: Words leave in the order written. `rd_data`, `rd_sof` and `rd_eof` show the oldest stored word, and a word is removed on a cycle where `rd_valid` and `rd_accept` are both 1.
- R7: `cfg_err` is 1 exactly when `bp_thresh` <= `full_thresh`, or when `af_level` > DEPTH-4.
- R8: A write arriving while the buffer holds DEPTH words is dropped and sets `overflow`. `overflow` stays 1 until reset.
- R9: While frame starts are held off, writes continue to be stored until occupancy reaches `af_level`, and `wr_ready` then goes to 0.
- R10: During and right after reset the buffer is empty, and `rd_valid`, `overflow` and `wr_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | DATA_W | Write word |
| wr_valid | input | 1 | Write strobe |
| wr_sof | input | 1 | Word is the first of a frame |
| wr_eof | input | 1 | Word is the last of a frame |
| wr_ready | output | 1 | Writer may continue (almost-full flow control) |
| rd_data | output | DATA_W | Oldest stored word |
| rd_sof | output | 1 | Oldest word starts a frame |
| rd_eof | output | 1 | Oldest word ends a frame |
| rd_valid | output | 1 | Word offered to the switch core |
| rd_accept | input | 1 | Switch core takes the offered word |
| free_cells | input | CELL_W | Free cells in the shared output memory |
| bp_thresh | input | CELL_W | Backpressure threshold on free cells |
| full_thresh | input | CELL_W | Memory-full (discard) threshold, checked only |
| af_level | input | $clog2(DEPTH+1) | Almost-full occupancy level |
| cfg_err | output | 1 | Threshold configuration error |
| overflow | output | 1 | Sticky flag: a write was dropped |

## Verification
The assertions assume the writer sends well-formed frames: each frame opens with a start marker, closes with an end marker, and is never longer than the buffer. Under that assumption, a frame counted as complete is always the oldest data in the buffer. They also assume `af_level` only changes on cycles the ready check does not depend on, which is why the ready property is gated on a stable level. The stimulus builds frames of one to six words. In its random phase it waits on `wr_ready` before every word. It deliberately overruns ready or fills the buffer only in directed phases, and after the overflow phase it resets the block before sending well-formed traffic again.

// File: rtl/ifb_pkg.sv
package ifb_pkg;

  // Words a writer may still push after it sees ready low
  localparam int unsigned OVERRUN_WORDS = 4;

  // Threshold sanity: backpressure must sit above memory-full, and the
  // almost-full level must leave room for the writer's overrun.
  function automatic logic thresholds_bad(input int unsigned bp,
                                          input int unsigned full,
                                          input int unsigned af,
                                          input int unsigned depth);
    return (bp <= full) || (af + OVERRUN_WORDS > depth);
  endfunction

  // Occupancy after one cycle of push/pop
  function automatic int unsigned occ_after(input int unsigned occ,
                                            input logic push,
                                            input logic pop);
    return occ + {31'b0, push} - {31'b0, pop};
  endfunction

endpackage

// File: rtl/ifb_store.sv
module ifb_store #(
  parameter int W     = 34,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count
);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      cnt_q <= CNT_W'(ifb_pkg::occ_after(32'(cnt_q), push, pop));
    end
  end

  assign head  = mem[rd_ptr];
  assign count = cnt_q;

  // R6: never remove from an empty store
  a_r6_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

  // R8: never store into a full store
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count != CNT_W'(DEPTH)));

endmodule

// File: rtl/ifb_wr_flow.sv
module ifb_wr_flow #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             pop,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] af_level,
  output logic             push,
  output logic             wr_ready,
  output logic             overflow
);

  logic             full;
  logic             drop_evt;
  logic [CNT_W-1:0] next_occ;
  logic             ready_q;
  logic             ovf_q;

  assign full     = (count == CNT_W'(DEPTH));
  assign push     = wr_valid && !full;
  assign drop_evt = wr_valid && full;
  assign next_occ = CNT_W'(ifb_pkg::occ_after(32'(count), push, pop));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      ready_q <= (next_occ < af_level);
      ovf_q   <= ovf_q | drop_evt;
    end
  end

  assign wr_ready = ready_q;
  assign overflow = ovf_q;

  // R8: overflow never clears outside reset
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R8: overflow only rises after a write met a full buffer
  a_r8_overflow_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(wr_valid && full));

endmodule

// File: rtl/ifb_read_gate.sv
module ifb_read_gate #(
  parameter int DEPTH  = 16,
  parameter int CELL_W = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic              head_eof,
  input  logic              push_eof,
  input  logic [CELL_W-1:0] free_cells,
  input  logic [CELL_W-1:0] bp_thresh,
  input  logic              rd_accept,
  output logic              rd_valid,
  output logic              pop
);

  logic [CNT_W-1:0] eof_cnt;
  logic             in_frame;
  logic             start_ok;
  logic             frame_held;
  logic             pop_eof;

  assign start_ok   = (free_cells >= bp_thresh);
  assign frame_held = (eof_cnt != '0);
  assign rd_valid   = in_frame || (frame_held && start_ok);
  assign pop        = rd_valid && rd_accept;
  assign pop_eof    = pop && head_eof;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eof_cnt  <= '0;
      in_frame <= 1'b0;
    end else begin
      eof_cnt <= CNT_W'(ifb_pkg::occ_after(32'(eof_cnt), push_eof, pop_eof));
      if (pop) in_frame <= !head_eof;
    end
  end

  // R3: no new frame start while shared memory is short of cells
  a_r3_hold_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && (free_cells < bp_thresh)) |-> !rd_valid);

  // R4: a started frame keeps being offered to its end
  a_r4_finish_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_accept && !head_eof) |=> rd_valid);

  // R5: complete frames counted never exceed stored words
  a_r5_complete_only: assert property (@(posedge clk) disable iff (!rst_n)
    eof_cnt <= count);

  // R5: something is stored whenever a word is offered
  a_r5_offer_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (count != '0));

endmodule

// File: rtl/ingress_frame_buffer.sv
module ingress_frame_buffer #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CELL_W = 10,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int WORD_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  input  logic              wr_sof,
  input  logic              wr_eof,
  output logic              wr_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sof,
  output logic              rd_eof,
  output logic              rd_valid,
  input  logic              rd_accept,
  input  logic [CELL_W-1:0] free_cells,
  input  logic [CELL_W-1:0] bp_thresh,
  input  logic [CELL_W-1:0] full_thresh,
  input  logic [CNT_W-1:0]  af_level,
  output logic              cfg_err,
  output logic              overflow
);

  logic              push, pop;
  logic [WORD_W-1:0] din, head;
  logic [CNT_W-1:0]  count;

  assign din = {wr_sof, wr_eof, wr_data};

  ifb_store #(.W(WORD_W), .DEPTH(DEPTH)) i_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .din   (din),
    .head  (head),
    .count (count)
  );

  ifb_wr_flow #(.DEPTH(DEPTH)) i_wr_flow (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .pop      (pop),
    .count    (count),
    .af_level (af_level),
    .push     (push),
    .wr_ready (wr_ready),
    .overflow (overflow)
  );

  ifb_read_gate #(.DEPTH(DEPTH), .CELL_W(CELL_W)) i_read_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .count      (count),
    .head_eof   (head[DATA_W]),
    .push_eof   (push && wr_eof),
    .free_cells (free_cells),
    .bp_thresh  (bp_thresh),
    .rd_accept  (rd_accept),
    .rd_valid   (rd_valid),
    .pop        (pop)
  );

  assign rd_data = head[DATA_W-1:0];
  assign rd_eof  = head[DATA_W];
  assign rd_sof  = head[DATA_W+1];

  assign cfg_err = ifb_pkg::thresholds_bad(32'(bp_thresh), 32'(full_thresh),
                                           32'(af_level), DEPTH);

  // R1: with a steady level, ready is low whenever occupancy is at or above it
  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(af_level) && (count >= af_level)) |-> !wr_ready);

  // R2: with a sane level, a ready-honouring writer never meets a full buffer
  a_r2_headroom: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ready && !cfg_err && $stable(af_level)) |-> (count != CNT_W'(DEPTH)));

endmodule

// File: tb/test_ingress_frame_buffer.sv
module test_ingress_frame_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int CELL_W = 10;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_valid = 1'b0, wr_sof = 1'b0, wr_eof = 1'b0;
  logic wr_ready;
  logic [DATA_W-1:0] rd_data;
  logic rd_sof, rd_eof, rd_valid;
  logic rd_accept = 1'b0;
  logic [CELL_W-1:0] free_cells = 10'd1000;
  logic [CELL_W-1:0] bp_thresh = 10'd100;
  logic [CELL_W-1:0] full_thresh = 10'd50;
  logic [CNT_W-1:0] af_level = CNT_W'(12);
  logic cfg_err, overflow;

  int n_checks = 0;
  int n_fail = 0;
  bit started = 0;
  bit done = 0;

  // reference model state
  logic [DATA_W+1:0] mq[$];
  int m_eofs = 0;
  bit m_in_frame = 0;
  bit m_ovf = 0;
  bit m_ready = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ingress_frame_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CELL_W(CELL_W)) i_ingress_frame_buffer (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_valid(wr_valid),
    .wr_sof(wr_sof), .wr_eof(wr_eof), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_sof(rd_sof), .rd_eof(rd_eof), .rd_valid(rd_valid),
    .rd_accept(rd_accept), .free_cells(free_cells), .bp_thresh(bp_thresh),
    .full_thresh(full_thresh), .af_level(af_level), .cfg_err(cfg_err),
    .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // model update on every edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_eofs = 0; m_in_frame = 0; m_ovf = 0; m_ready = 0;
    end else begin
      automatic bit v = m_in_frame || (m_eofs > 0 && free_cells >= bp_thresh);
      automatic bit do_pop = v && rd_accept;
      automatic bit do_push = wr_valid && (mq.size() < DEPTH);
      automatic logic [DATA_W+1:0] h;
      if (wr_valid && mq.size() == DEPTH) m_ovf = 1;
      if (do_pop) begin
        h = mq.pop_front();
        if (h[DATA_W]) m_eofs--;
        m_in_frame = !h[DATA_W];
      end
      if (do_push) begin
        mq.push_back({wr_sof, wr_eof, wr_data});
        if (wr_eof) m_eofs++;
      end
      m_ready = (mq.size() < int'(af_level));
    end
  end

  // compare mid-cycle
  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      automatic bit exp_v = m_in_frame || (m_eofs > 0 && free_cells >= bp_thresh);
      automatic bit exp_cfg = (bp_thresh <= full_thresh) || (int'(af_level) > DEPTH - 4);
      check(wr_ready === m_ready, "R1 ready", wr_ready, m_ready);
      check(rd_valid === exp_v, "R3 R4 R5 rd_valid", rd_valid, exp_v);
      if (exp_v && rd_valid)
        check({rd_sof, rd_eof, rd_data} === mq[0], "R6 head word",
              {rd_sof, rd_eof, rd_data}, mq[0]);
      check(overflow === m_ovf, "R8 overflow", overflow, m_ovf);
      check(cfg_err === exp_cfg, "R7 cfg_err", cfg_err, exp_cfg);
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input int d, input bit s, input bit e);
    wr_valid = 1'b1; wr_data = DATA_W'(d); wr_sof = s; wr_eof = e;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) step();
    // R10: reset state
    check(wr_ready == 1'b0, "R10 ready in reset", wr_ready, 0);
    check(rd_valid == 1'b0, "R10 rd_valid in reset", rd_valid, 0);
    check(overflow == 1'b0, "R10 overflow in reset", overflow, 0);
    rst_n = 1'b1;
    started = 1;
    step();
    check(wr_ready == 1'b1, "R1 ready after reset", wr_ready, 1);

    // R7: configuration checks
    bp_thresh = 10'd50; step();
    check(cfg_err == 1'b1, "R7 bp equal full", cfg_err, 1);
    bp_thresh = 10'd51; step();
    check(cfg_err == 1'b0, "R7 bp above full", cfg_err, 0);
    af_level = CNT_W'(13); step();
    check(cfg_err == 1'b1, "R7 af too high", cfg_err, 1);
    af_level = CNT_W'(12); bp_thresh = 10'd100; step();

    // R6: short frames flowing through
    rd_accept = 1'b1;
    for (int f = 1; f <= 4; f++)
      for (int i = 0; i < f; i++) drive(16'h100 * f + i, i == 0, i == f - 1);
    repeat (20) step();

    // R9 / R2: hold off starts, overrun by 4 after ready drops
    free_cells = 10'd10;
    begin
      int i = 0;
      while (wr_ready) begin drive(16'h200 + i, (i % 4) == 0, (i % 4) == 3); i++; end
      check(i == 12, "R9 ready dropped at level", i, 12);
      for (int k = 0; k < 4; k++) begin drive(16'h200 + i, (i % 4) == 0, (i % 4) == 3); i++; end
    end
    step();
    check(overflow == 1'b0, "R2 overrun absorbed", overflow, 0);
    check(wr_ready == 1'b0, "R9 ready low while held", wr_ready, 0);
    check(rd_valid == 1'b0, "R3 start held", rd_valid, 0);
    free_cells = 10'd1000;
    repeat (40) step();

    // R4 / R3: frame started before cells run short completes
    rd_accept = 1'b0;
    for (int i = 0; i < 5; i++) drive(16'h500 + i, i == 0, i == 4);
    step();
    check(rd_valid == 1'b1, "R5 complete frame offered", rd_valid, 1);
    rd_accept = 1'b1; step();
    rd_accept = 1'b0; free_cells = 10'd10; step();
    check(rd_valid == 1'b1, "R4 mid-frame continues", rd_valid, 1);
    repeat (3) step();
    check(rd_valid == 1'b1, "R4 still offered", rd_valid, 1);
    rd_accept = 1'b1; repeat (4) step();
    rd_accept = 1'b0;
    for (int i = 0; i < 2; i++) drive(16'h600 + i, i == 0, i == 1);
    step();
    check(rd_valid == 1'b0, "R3 next frame held", rd_valid, 0);
    free_cells = 10'd1000; step();
    check(rd_valid == 1'b1, "R3 released", rd_valid, 1);
    rd_accept = 1'b1; repeat (5) step();

    // R5: incomplete frame is not offered
    rd_accept = 1'b0;
    drive(16'h700, 1, 0); drive(16'h701, 0, 0); step();
    check(rd_valid == 1'b0, "R5 partial not offered", rd_valid, 0);
    drive(16'h702, 0, 1); step();
    check(rd_valid == 1'b1, "R5 offered after eof", rd_valid, 1);
    rd_accept = 1'b1; repeat (6) step();

    // R8: overflow
    rd_accept = 1'b0; free_cells = 10'd10;
    for (int i = 0; i < 18; i++) drive(16'h800 + i, (i % 3) == 0, (i % 3) == 2);
    step();
    check(overflow == 1'b1, "R8 overflow set", overflow, 1);
    free_cells = 10'd1000; rd_accept = 1'b1;
    repeat (30) step();
    check(overflow == 1'b1, "R8 overflow sticky", overflow, 1);
    rst_n = 1'b0; step(); step();
    check(overflow == 1'b0, "R10 overflow cleared", overflow, 0);
    check(rd_valid == 1'b0, "R10 empty after reset", rd_valid, 0);
    rst_n = 1'b1; step();

    // random well-formed traffic
    for (int f = 0; f < 400; f++) begin
      automatic int len = $urandom_range(1, 6);
      for (int i = 0; i < len; i++) begin
        while (!wr_ready) begin
          free_cells = CELL_W'($urandom_range(80, 120));
          rd_accept = ($urandom_range(0, 3) != 0);
          step();
        end
        free_cells = CELL_W'($urandom_range(80, 120));
        rd_accept = ($urandom_range(0, 3) != 0);
        drive(f * 16 + i, i == 0, i == len - 1);
        if ($urandom_range(0, 3) == 0) step();
      end
    end
    free_cells = 10'd1000; rd_accept = 1'b1;
    repeat (40) step();
    check(rd_valid == 1'b0, "R6 drained", rd_valid, 0);
    finish_run();
  end
endmodule